// File: doc/BRIEF.md
# Video SRAM Write Port

This block lets a 68000-style asynchronous processor bus write single bytes into a video SRAM that a display fetch engine also reads. A processor write is captured into a holding register. It is then placed on the SRAM in a cycle that the display engine is not using. The bus acknowledge (`cpu_dtack_n`) is held high until the SRAM write pulse has fully completed. This means the processor cannot start another write while a byte is still pending, even when display reads have held that byte back.

The display engine asks for one SRAM read per cycle with `disp_req`. The port answers one cycle later with either a grant or a refusal, and returns read data one cycle after a grant. Display reads normally take priority. A write that has waited `MAX_WAIT` cycles takes the memory anyway, and display requests that collide with it are refused so that the engine can substitute a blank value. An optional gate drops display requests outside the visible area, which frees those cycles for writes.

Processor control strobes pass through a synchronizer of `SYNC_STAGES` flops. The SRAM is byte wide and its chip enable is held permanently active. The data bus is split into `sram_wdata` and `sram_rdata`, and the bidirectional pad sits outside this block.

Top module: `vram_wr_port`

## Requirements
- R1: While reset is held and after it is released, `cpu_dtack_n`, `sram_we_n` and `sram_oe_n` are high, and `disp_grant`, `disp_refused` and `disp_rvalid` are low.
- R2: A write with only `cpu_uds_n` low produces one SRAM write of `cpu_wdata[15:8]` to byte address `{cpu_addr,1'b0}`. A write with only `cpu_lds_n` low produces one SRAM write of `cpu_wdata[7:0]` to `{cpu_addr,1'b1}`.
- R3: A write with both strobes low produces two SRAM writes, even address first, then odd. With no display traffic, `cpu_dtack_n` falls at rising edge SYNC_STAGES+2*WE_CYCLES+8, counting the first edge after `cpu_as_n` and the strobes go low as edge 1.
- R4: With no display traffic, a byte write drives `cpu_dtack_n` low at rising edge SYNC_STAGES+WE_CYCLES+5 (edge 8 by default), and never before the write pulse has ended.
- R5: Each SRAM write holds `sram_we_n` low for WE_CYCLES cycles. `sram_addr` and `sram_wdata` are set one cycle before the pulse and held through one cycle after it.
- R6: `cpu_dtack_n` stays low until `cpu_as_n` goes high, and returns high at rising edge SYNC_STAGES+1 after that.
- R7: Changes on `cpu_addr` and `cpu_wdata` after the write has been latched (edge SYNC_STAGES+1) do not change the byte or address written.
- R8: A bus cycle with `cpu_rw` high is ignored: `cpu_dtack_n` stays high and no SRAM write occurs.
- R9: A display request in a free cycle gives `disp_grant` high one cycle later, with `sram_oe_n` low and `sram_addr` equal to that `disp_addr`. On the next cycle, `disp_rvalid` is high and `disp_rdata` holds the SRAM data.
- R10: A pending write waits while display requests are present, and the display is granted in those cycles. A read and a write never overlap (`sram_we_n` and `sram_oe_n` are never both low).
- R11: After a write has waited MAX_WAIT cycles, it takes the memory. Display requests in that cycle and in each write cycle are answered with `disp_refused`, never together with `disp_grant`. Under continuous requests, a byte write acknowledges at edge SYNC_STAGES+WE_CYCLES+5+MAX_WAIT.
- R12: With GATE_BLANK set, a request with `disp_visible` low is dropped: no grant, no refusal, no SRAM read, and no delay to a pending write.
- R13: `sram_ce_n` is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | CPU_AW | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_uds_n | input | 1 | Upper (even) byte strobe, active low |
| cpu_lds_n | input | 1 | Lower (odd) byte strobe, active low |
| cpu_rw | input | 1 | High for read, low for write |
| cpu_dtack_n | output | 1 | Bus acknowledge, active low |
| sram_addr | output | CPU_AW+1 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip enable, held low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| disp_req | input | 1 | Display read request for this cycle |
| disp_visible | input | 1 | Display is inside the visible area |
| disp_addr | input | CPU_AW+1 | Display read byte address |
| disp_grant | output | 1 | Request of the previous cycle was served |
| disp_refused | output | 1 | Request of the previous cycle was refused |
| disp_rvalid | output | 1 | `disp_rdata` holds read data |
| disp_rdata | output | 8 | Display read data |

## Verification
The bench targets acknowledge timing against write completion. If acknowledge is tied to acceptance instead of completion, `cpu_dtack_n` falls several edges early and the latency checks catch it. Word writes must produce two pulses in even-then-odd order, and a lane swap shows up as wrong addresses or bytes. Under continuous display traffic, a missing starvation limit hangs the write, and a wrong limit shifts the acknowledge edge and the refusal count. The bench also confirms that invisible requests and read cycles leave the memory untouched, and that bus data changing after latching cannot corrupt the pending byte.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

    // Write sequencer states
    typedef enum logic [2:0] {
        WR_IDLE,
        WR_LATCH,
        WR_WAIT_SLOT,
        WR_WRITE,
        WR_ACK
    } wr_state_e;

    // Index of each synchronized strobe in the sync vector
    localparam int SIG_AS  = 3;
    localparam int SIG_UDS = 2;
    localparam int SIG_LDS = 1;
    localparam int SIG_WR  = 0;
    localparam int SIG_NUM = 4;

endpackage

// File: rtl/vsw_sync.sv
module vsw_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    logic [STAGES-1:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign sync_out = pipe_q[STAGES-1];

endmodule

// File: rtl/vsw_slot_arb.sv
module vsw_slot_arb #(
    parameter bit GATE_BLANK = 1'b1
) (
    input  logic disp_req,
    input  logic disp_visible,
    input  logic wr_busy,
    input  logic wr_waiting,
    input  logic wr_starve,
    output logic rd_grant,
    output logic rd_refuse,
    output logic wr_go
);

    // When gating is off every request counts as visible
    localparam logic PASS_BLANK = !GATE_BLANK;

    logic disp_ok;

    always_comb begin
        disp_ok   = disp_req & (disp_visible | PASS_BLANK);
        rd_grant  = disp_ok & ~wr_busy & ~wr_starve;
        rd_refuse = disp_ok & ~rd_grant;
        wr_go     = wr_waiting & (~disp_ok | wr_starve);
    end

endmodule

// File: rtl/vsw_wr_engine.sv
module vsw_wr_engine
    import vsw_pkg::*;
#(
    parameter int CPU_AW    = 14,
    parameter int WE_CYCLES = 1,
    parameter int MAX_WAIT  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                as_s,
    input  logic                uds_s,
    input  logic                lds_s,
    input  logic                wr_s,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [15:0]         cpu_wdata,
    input  logic                wr_go,
    output logic                wr_busy,
    output logic                wr_waiting,
    output logic                wr_starve,
    output logic [CPU_AW:0]     wr_addr,
    output logic [7:0]          wr_data,
    output logic                we_n,
    output logic                dtack_n
);

    localparam int SRAM_AW = CPU_AW + 1;
    localparam int PH_W    = $clog2(WE_CYCLES + 2);
    localparam int CNT_W   = $clog2(MAX_WAIT + 1);
    localparam logic [PH_W-1:0]  PH_LOW_END = PH_W'(WE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LIMIT  = CNT_W'(MAX_WAIT);

    typedef struct packed {
        wr_state_e           state;
        logic [PH_W-1:0]     ph;
        logic [CNT_W-1:0]    wait_cnt;
        logic [1:0]          pend;      // [1] even byte, [0] odd byte
        logic [CPU_AW-1:0]   lat_addr;
        logic [15:0]         lat_data;
        logic [SRAM_AW-1:0]  addr;
        logic [7:0]          wdata;
        logic                we_n;
        logic                dtack_n;
    } wr_regs_t;

    localparam wr_regs_t WR_RESET = '{
        state:    WR_IDLE,
        ph:       '0,
        wait_cnt: '0,
        pend:     '0,
        lat_addr: '0,
        lat_data: '0,
        addr:     '0,
        wdata:    '0,
        we_n:     1'b1,
        dtack_n:  1'b1
    };

    wr_regs_t r_q, r_d;
    logic [1:0] pend_left;

    always_comb begin
        r_d       = r_q;
        pend_left = r_q.pend[1] ? {1'b0, r_q.pend[0]} : 2'b00;
        case (r_q.state)
            WR_IDLE: begin
                if (as_s && wr_s && (uds_s || lds_s)) begin
                    r_d.state    = WR_LATCH;
                    r_d.lat_addr = cpu_addr;
                    r_d.lat_data = cpu_wdata;
                    r_d.pend     = {uds_s, lds_s};
                end
            end
            WR_LATCH: begin
                r_d.state    = WR_WAIT_SLOT;
                r_d.wait_cnt = '0;
            end
            WR_WAIT_SLOT: begin
                if (wr_go) begin
                    r_d.state = WR_WRITE;
                    r_d.ph    = '0;
                    r_d.addr  = {r_q.lat_addr, ~r_q.pend[1]};
                    r_d.wdata = r_q.pend[1] ? r_q.lat_data[15:8] : r_q.lat_data[7:0];
                end else if (r_q.wait_cnt != CNT_LIMIT) begin
                    r_d.wait_cnt = r_q.wait_cnt + 1'b1;
                end
            end
            WR_WRITE: begin
                if (r_q.ph < PH_LOW_END) begin
                    r_d.ph   = r_q.ph + 1'b1;
                    r_d.we_n = 1'b0;
                end else if (r_q.ph == PH_LOW_END) begin
                    r_d.ph   = r_q.ph + 1'b1;
                    r_d.we_n = 1'b1;
                end else begin
                    r_d.pend = pend_left;
                    if (pend_left != 2'b00) begin
                        r_d.state    = WR_WAIT_SLOT;
                        r_d.wait_cnt = '0;
                    end else begin
                        r_d.state   = WR_ACK;
                        r_d.dtack_n = 1'b0;
                    end
                end
            end
            WR_ACK: begin
                if (!as_s) begin
                    r_d.state   = WR_IDLE;
                    r_d.dtack_n = 1'b1;
                end
            end
            default: r_d = WR_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= WR_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_busy    = (r_q.state == WR_WRITE);
    assign wr_waiting = (r_q.state == WR_WAIT_SLOT);
    assign wr_starve  = wr_waiting && (r_q.wait_cnt == CNT_LIMIT);
    assign wr_addr    = r_q.addr;
    assign wr_data    = r_q.wdata;
    assign we_n       = r_q.we_n;
    assign dtack_n    = r_q.dtack_n;

endmodule

// File: rtl/vsw_rd_path.sv
module vsw_rd_path #(
    parameter int SRAM_AW = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_grant,
    input  logic               rd_refuse,
    input  logic [SRAM_AW-1:0] disp_addr,
    input  logic [7:0]         sram_rdata,
    output logic               oe_n,
    output logic [SRAM_AW-1:0] rd_addr,
    output logic               disp_grant,
    output logic               disp_refused,
    output logic               disp_rvalid,
    output logic [7:0]         disp_rdata
);

    typedef struct packed {
        logic               oe_n;
        logic [SRAM_AW-1:0] raddr;
        logic               grant;
        logic               refused;
        logic               rvalid;
        logic [7:0]         rdata;
    } rd_regs_t;

    localparam rd_regs_t RD_RESET = '{
        oe_n:    1'b1,
        raddr:   '0,
        grant:   1'b0,
        refused: 1'b0,
        rvalid:  1'b0,
        rdata:   '0
    };

    rd_regs_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        r_d.oe_n    = ~rd_grant;
        r_d.grant   = rd_grant;
        r_d.refused = rd_refuse;
        r_d.rvalid  = ~r_q.oe_n;
        if (rd_grant) begin
            r_d.raddr = disp_addr;
        end
        if (!r_q.oe_n) begin
            r_d.rdata = sram_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RD_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign oe_n         = r_q.oe_n;
    assign rd_addr      = r_q.raddr;
    assign disp_grant   = r_q.grant;
    assign disp_refused = r_q.refused;
    assign disp_rvalid  = r_q.rvalid;
    assign disp_rdata   = r_q.rdata;

endmodule

// File: rtl/vram_wr_port.sv
module vram_wr_port
    import vsw_pkg::*;
#(
    parameter int CPU_AW      = 14,
    parameter int SYNC_STAGES = 2,
    parameter int WE_CYCLES   = 1,
    parameter int MAX_WAIT    = 8,
    parameter bit GATE_BLANK  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    input  logic              cpu_as_n,
    input  logic              cpu_uds_n,
    input  logic              cpu_lds_n,
    input  logic              cpu_rw,
    output logic              cpu_dtack_n,
    output logic [CPU_AW:0]   sram_addr,
    output logic [7:0]        sram_wdata,
    input  logic [7:0]        sram_rdata,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    input  logic              disp_req,
    input  logic              disp_visible,
    input  logic [CPU_AW:0]   disp_addr,
    output logic              disp_grant,
    output logic              disp_refused,
    output logic              disp_rvalid,
    output logic [7:0]        disp_rdata
);

    localparam int SRAM_AW = CPU_AW + 1;

    logic [SIG_NUM-1:0] strobe_raw, strobe_s;
    logic wr_busy, wr_waiting, wr_starve, wr_go;
    logic rd_grant, rd_refuse, rd_oe_n;
    logic [SRAM_AW-1:0] wr_addr, rd_addr;

    always_comb begin
        strobe_raw          = '0;
        strobe_raw[SIG_AS]  = ~cpu_as_n;
        strobe_raw[SIG_UDS] = ~cpu_uds_n;
        strobe_raw[SIG_LDS] = ~cpu_lds_n;
        strobe_raw[SIG_WR]  = ~cpu_rw;
    end

    vsw_sync #(.N(SIG_NUM), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (strobe_raw),
        .sync_out (strobe_s)
    );

    vsw_wr_engine #(
        .CPU_AW    (CPU_AW),
        .WE_CYCLES (WE_CYCLES),
        .MAX_WAIT  (MAX_WAIT)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_s       (strobe_s[SIG_AS]),
        .uds_s      (strobe_s[SIG_UDS]),
        .lds_s      (strobe_s[SIG_LDS]),
        .wr_s       (strobe_s[SIG_WR]),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .wr_go      (wr_go),
        .wr_busy    (wr_busy),
        .wr_waiting (wr_waiting),
        .wr_starve  (wr_starve),
        .wr_addr    (wr_addr),
        .wr_data    (sram_wdata),
        .we_n       (sram_we_n),
        .dtack_n    (cpu_dtack_n)
    );

    vsw_slot_arb #(.GATE_BLANK(GATE_BLANK)) u_arb (
        .disp_req     (disp_req),
        .disp_visible (disp_visible),
        .wr_busy      (wr_busy),
        .wr_waiting   (wr_waiting),
        .wr_starve    (wr_starve),
        .rd_grant     (rd_grant),
        .rd_refuse    (rd_refuse),
        .wr_go        (wr_go)
    );

    vsw_rd_path #(.SRAM_AW(SRAM_AW)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_grant     (rd_grant),
        .rd_refuse    (rd_refuse),
        .disp_addr    (disp_addr),
        .sram_rdata   (sram_rdata),
        .oe_n         (rd_oe_n),
        .rd_addr      (rd_addr),
        .disp_grant   (disp_grant),
        .disp_refused (disp_refused),
        .disp_rvalid  (disp_rvalid),
        .disp_rdata   (disp_rdata)
    );

    // Only one SRAM device is fitted; its enable never deasserts
    assign sram_ce_n = 1'b0;
    assign sram_oe_n = rd_oe_n;
    assign sram_addr = rd_oe_n ? wr_addr : rd_addr;

endmodule

// File: rtl/vram_wr_port_chk.sv
module vram_wr_port_chk #(
    parameter int SRAM_AW = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_as_n,
    input logic               cpu_dtack_n,
    input logic [SRAM_AW-1:0] sram_addr,
    input logic [7:0]         sram_wdata,
    input logic               sram_we_n,
    input logic               sram_oe_n,
    input logic               disp_grant,
    input logic               disp_refused,
    input logic               disp_rvalid
);

    // R4
    ack_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_dtack_n) |-> ($past(sram_we_n, 1) && !$past(sram_we_n, 2)));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> ($stable(sram_addr) && $stable(sram_wdata)));

    // R5
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_wdata)));

    // R6
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_dtack_n) |-> $past(cpu_as_n));

    // R9
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_grant |=> disp_rvalid);

    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    // R11
    grant_refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_grant && disp_refused));

endmodule

bind vram_wr_port vram_wr_port_chk #(.SRAM_AW(SRAM_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_as_n     (cpu_as_n),
    .cpu_dtack_n  (cpu_dtack_n),
    .sram_addr    (sram_addr),
    .sram_wdata   (sram_wdata),
    .sram_we_n    (sram_we_n),
    .sram_oe_n    (sram_oe_n),
    .disp_grant   (disp_grant),
    .disp_refused (disp_refused),
    .disp_rvalid  (disp_rvalid)
);

// File: tb/vram_wr_port_test.sv
`timescale 1ns/1ps
module vram_wr_port_test;

    localparam int CPU_AW    = 6;
    localparam int SAW       = CPU_AW + 1;
    localparam int SYNC      = 2;
    localparam int WEC       = 1;
    localparam int MAXW      = 8;
    localparam int BYTE_LAT  = SYNC + WEC + 5;
    localparam int REL_LAT   = SYNC + 1;
    localparam int STARVE_LAT = BYTE_LAT + MAXW;

    // {uds_on, lds_on, addr[5:0], data[15:0], expected ack edge[7:0]}
    localparam logic [31:0] VEC [6] = '{
        {1'b1, 1'b0, 6'h05, 16'hA15C, 8'd8},
        {1'b0, 1'b1, 6'h05, 16'h33C7, 8'd8},
        {1'b1, 1'b1, 6'h3F, 16'hBEEF, 8'd12},
        {1'b1, 1'b0, 6'h00, 16'h0080, 8'd8},
        {1'b1, 1'b1, 6'h12, 16'h0102, 8'd12},
        {1'b0, 1'b1, 6'h2A, 16'hFF00, 8'd8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CPU_AW-1:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic cpu_as_n = 1'b1, cpu_uds_n = 1'b1, cpu_lds_n = 1'b1, cpu_rw = 1'b1;
    logic cpu_dtack_n;
    logic [SAW-1:0] sram_addr;
    logic [7:0] sram_wdata, sram_rdata;
    logic sram_ce_n, sram_we_n, sram_oe_n;
    logic disp_req = 1'b0, disp_visible = 1'b0;
    logic [SAW-1:0] disp_addr = '0;
    logic disp_grant, disp_refused, disp_rvalid;
    logic [7:0] disp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // SRAM read model: data is a fixed function of the address
    assign sram_rdata = {1'b0, sram_addr} ^ 8'h5A;

    vram_wr_port #(
        .CPU_AW(CPU_AW), .SYNC_STAGES(SYNC), .WE_CYCLES(WEC),
        .MAX_WAIT(MAXW), .GATE_BLANK(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_as_n(cpu_as_n), .cpu_uds_n(cpu_uds_n), .cpu_lds_n(cpu_lds_n),
        .cpu_rw(cpu_rw), .cpu_dtack_n(cpu_dtack_n), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .disp_req(disp_req),
        .disp_visible(disp_visible), .disp_addr(disp_addr), .disp_grant(disp_grant),
        .disp_refused(disp_refused), .disp_rvalid(disp_rvalid), .disp_rdata(disp_rdata)
    );

    // Port monitor, sampled mid-cycle
    int pulse_n = 0;
    logic [SAW-1:0] p_addr [8];
    logic [7:0] p_data [8];
    int p_len [8];
    int ref_cnt = 0, gnt_cnt = 0, oe_cnt = 0, ce_bad = 0;
    logic we_prev = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_we_n) begin
                if (we_prev && pulse_n < 8) begin
                    p_addr[pulse_n] = sram_addr;
                    p_data[pulse_n] = sram_wdata;
                    p_len[pulse_n]  = 1;
                    pulse_n++;
                end else if (pulse_n > 0 && pulse_n <= 8) begin
                    p_len[pulse_n-1]++;
                end
            end
            we_prev = sram_we_n;
            if (disp_refused) ref_cnt++;
            if (disp_grant) gnt_cnt++;
            if (!sram_oe_n) oe_cnt++;
            if (sram_ce_n) ce_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        pulse_n = 0;
        ref_cnt = 0;
        gnt_cnt = 0;
        oe_cnt  = 0;
    endtask

    // Called just after a falling edge
    task automatic cpu_write(input bit u, input bit l, input logic [CPU_AW-1:0] a,
                             input logic [15:0] d, input bit corrupt,
                             output int lat, output int rel);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_rw    = 1'b0;
        cpu_as_n  = 1'b0;
        cpu_uds_n = !u;
        cpu_lds_n = !l;
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (corrupt && lat == SYNC + 2) begin
                cpu_wdata = ~d;
                cpu_addr  = ~a;
            end
        end while (cpu_dtack_n && lat < 200);
        cpu_as_n  = 1'b1;
        cpu_uds_n = 1'b1;
        cpu_lds_n = 1'b1;
        cpu_rw    = 1'b1;
        rel = 0;
        do begin
            @(posedge clk); rel++;
            @(negedge clk);
        end while (!cpu_dtack_n && rel < 200);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat, rel;
        // R1, R13: reset state
        repeat (3) @(negedge clk);
        chk(cpu_dtack_n == 1'b1, "R1", "dtack in reset", cpu_dtack_n, 1);
        chk(sram_we_n == 1'b1 && sram_oe_n == 1'b1, "R1", "we/oe in reset",
            {sram_we_n, sram_oe_n}, 3);
        chk(sram_ce_n == 1'b0, "R13", "ce in reset", sram_ce_n, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({disp_grant, disp_refused, disp_rvalid} == 3'b000, "R1", "display outputs idle",
            {disp_grant, disp_refused, disp_rvalid}, 0);
        chk(cpu_dtack_n == 1'b1 && sram_we_n == 1'b1, "R1", "dtack/we after reset",
            {cpu_dtack_n, sram_we_n}, 3);

        // Vector walk: byte and word writes, no display traffic
        for (int i = 0; i < 6; i++) begin
            logic [31:0] e;
            bit u, l;
            logic [5:0] a;
            logic [15:0] d;
            int np;
            e = VEC[i];
            u = e[31]; l = e[30]; a = e[29:24]; d = e[23:8];
            np = int'(u) + int'(l);
            clear_log();
            cpu_write(u, l, a, d, 1'b0, lat, rel);
            chk(lat == int'(e[7:0]), (u && l) ? "R3" : "R4", "ack edge", lat, e[7:0]);
            chk(pulse_n == np, (u && l) ? "R3" : "R2", "write pulse count", pulse_n, np);
            if (pulse_n == np) begin
                if (u) begin
                    chk(p_addr[0] == {a, 1'b0} && p_data[0] == d[15:8], "R2",
                        "even lane write", {p_addr[0], p_data[0]}, {a, 1'b0, d[15:8]});
                end else begin
                    chk(p_addr[0] == {a, 1'b1} && p_data[0] == d[7:0], "R2",
                        "odd lane write", {p_addr[0], p_data[0]}, {a, 1'b1, d[7:0]});
                end
                if (u && l) begin
                    chk(p_addr[1] == {a, 1'b1} && p_data[1] == d[7:0], "R3",
                        "second word byte", {p_addr[1], p_data[1]}, {a, 1'b1, d[7:0]});
                end
                chk(p_len[0] == WEC, "R5", "we low cycles", p_len[0], WEC);
            end
            chk(rel == REL_LAT, "R6", "dtack release edge", rel, REL_LAT);
            repeat (2) @(negedge clk);
        end

        // R7: bus data changes after latching
        clear_log();
        cpu_write(1'b0, 1'b1, 6'h21, 16'h4D96, 1'b1, lat, rel);
        chk(pulse_n == 1 && p_addr[0] == 7'h43 && p_data[0] == 8'h96, "R7",
            "latched byte kept", {p_addr[0], p_data[0]}, {7'h43, 8'h96});
        repeat (2) @(negedge clk);

        // R8: read cycle ignored
        clear_log();
        cpu_addr = 6'h07; cpu_rw = 1'b1; cpu_as_n = 1'b0; cpu_lds_n = 1'b0;
        rel = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!cpu_dtack_n) rel++;
        end
        chk(rel == 0, "R8", "dtack cycles on read", rel, 0);
        chk(pulse_n == 0, "R8", "writes on read", pulse_n, 0);
        cpu_as_n = 1'b1; cpu_lds_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: display read in an idle cycle
        clear_log();
        disp_req = 1'b1; disp_visible = 1'b1; disp_addr = 7'h2C;
        @(posedge clk); @(negedge clk);
        chk(disp_grant && !sram_oe_n && sram_addr == 7'h2C, "R9", "grant with address",
            {disp_grant, sram_oe_n, sram_addr}, {2'b10, 7'h2C});
        disp_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(disp_rvalid && disp_rdata == (8'h2C ^ 8'h5A), "R9", "read data",
            {disp_rvalid, disp_rdata}, {1'b1, 8'h2C ^ 8'h5A});
        chk(!disp_grant && sram_oe_n, "R9", "single read", {disp_grant, sram_oe_n}, 1);
        repeat (2) @(negedge clk);

        // R10, R11: continuous display requests against a byte write
        clear_log();
        disp_req = 1'b1; disp_visible = 1'b1; disp_addr = 7'h11;
        cpu_write(1'b1, 1'b0, 6'h09, 16'h5A00, 1'b0, lat, rel);
        disp_req = 1'b0;
        @(negedge clk);
        chk(lat == STARVE_LAT, "R11", "ack edge under display load", lat, STARVE_LAT);
        chk(ref_cnt == WEC + 3, "R11", "refused requests", ref_cnt, WEC + 3);
        chk(gnt_cnt >= MAXW, "R10", "display served while write waits", gnt_cnt, MAXW);
        chk(pulse_n == 1 && p_addr[0] == 7'h12 && p_data[0] == 8'h5A, "R10",
            "deferred write content", {p_addr[0], p_data[0]}, {7'h12, 8'h5A});
        repeat (2) @(negedge clk);

        // R12: invisible requests are dropped and do not delay writes
        clear_log();
        disp_req = 1'b1; disp_visible = 1'b0; disp_addr = 7'h33;
        cpu_write(1'b0, 1'b1, 6'h30, 16'h00E1, 1'b0, lat, rel);
        disp_req = 1'b0;
        @(negedge clk);
        chk(lat == BYTE_LAT, "R12", "ack edge with blank requests", lat, BYTE_LAT);
        chk(ref_cnt == 0 && gnt_cnt == 0, "R12", "grant/refuse on blank",
            ref_cnt + gnt_cnt, 0);
        chk(oe_cnt == 0, "R12", "sram reads on blank", oe_cnt, 0);
        chk(ce_bad == 0, "R13", "ce high cycles", ce_bad, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule